// File: doc/BRIEF.md
# Snooping Write-Back Coherence Cluster

This block is a small cluster of per-node cache controllers that keep direct-mapped write-back caches coherent over one shared broadcast bus. Each node holds a tag, data and state array. Every line is in one of three states: Invalid, Shared or Exclusive. A node serves its processor's reads and writes locally when it can. Otherwise it requests the bus through a round-robin arbiter and then drives one transaction. Every other node snoops that transaction in the same cycle.

A transaction completes in the cycle it is granted. During that cycle every foreign node looks up its own copy, and a node that holds the block dirty supplies the data and raises an abort so that memory yields. A memory stub on the bus returns data for read and write misses. It takes the data of write-backs and of owner interventions, so Shared data always matches memory. Writes to clean lines go out as full write misses, and evicting a dirty line writes it back before the new miss is issued.

The line state codes are internal. The bus command codes seen at the ports are: 0 idle, 1 read miss, 2 write miss, 3 write-back. A line is one data word. The low address bits select the line and the upper bits form the tag. The processor interface holds `cpu_req` and its operands high until `cpu_done` pulses. `cpu_done` is asserted in the cycle whose closing clock edge completes the access.

Top module: `coh_snoop_cluster`

## Requirements
- R1: After reset every line of every node is Invalid and memory holds zero. The first read of any address therefore misses and returns 0, and no bus transaction or completion is seen while reset is held.
- R2: A read that hits a Shared or Exclusive line, and a write that hits an Exclusive line, complete in the first cycle of the request with no bus transaction from that node.
- R3: A read miss completes in the grant cycle with a read-miss transaction (code 1) for the requested address. The line is then filled Shared with the returned data.
- R4: A write to a line that is Shared, Invalid or holds another block places a write-miss transaction (code 2) on the bus. The write completes only in that grant cycle, and the line becomes Exclusive with the written value.
- R5: When a foreign read miss hits a line held Exclusive, that node supplies its data and asserts `bus_abort`, and memory takes the supplied value. The line becomes Shared: a later read by that node hits without the bus, and a later write by it issues a write miss.
- R6: A foreign write miss invalidates a matching Shared line without an abort. A matching Exclusive line instead supplies its data with `bus_abort` and is invalidated. In both cases that node's next read of the block misses.
- R7: A miss to a line that holds a different block in Exclusive state first issues a write-back (code 3) of that block with its data, then issues the miss. Memory holds the written-back value afterwards.
- R8: In a cycle in which another node's transaction is on the bus, a node in the idle state does not complete a processor access. The access completes at the earliest in the next cycle.
- R9: At most one node is granted per cycle, and only a requesting node. Priority rotates: the node after the last granted one is first, and node 0 is first after reset.
- R10: At most one node supplies data for any transaction, and every read returns the value of the most recent write to that address in bus order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | NODES | Per-node access request, held until done |
| cpu_we | input | NODES | Per-node write enable (1 write, 0 read) |
| cpu_addr | input | NODES*ADDR_W | Per-node address, node i at bits [i*ADDR_W +: ADDR_W] |
| cpu_wdata | input | NODES*DATA_W | Per-node write data |
| cpu_done | output | NODES | Per-node completion pulse |
| cpu_rdata | output | NODES*DATA_W | Per-node read data, valid with done |
| bus_valid | output | 1 | A transaction is on the bus this cycle |
| bus_cmd | output | 2 | Bus command: 0 idle, 1 read miss, 2 write miss, 3 write-back |
| bus_addr | output | ADDR_W | Bus transaction address |
| bus_abort | output | 1 | A dirty owner supplies the data and memory yields |

## Verification
The in-line properties guard every cycle for these rules: a single grant given only to a requester, a single supplier per transaction, no abort on a write-back, no processor completion in a cycle of foreign snooping, a write miss that completes in its own grant cycle, and a write-back that is always followed by a miss request. The protocol outcomes are visible only through sequences, so the scoreboard scenarios cover them. These are the downgrade from Exclusive to Shared, invalidation by a foreign write, intervention data, write-back before a conflicting miss, round-robin order, and read values that follow the last write.

// File: rtl/coh_pkg.sv
// Shared types for the snooping coherence cluster.
// Assumes: bus command encodings are visible at the top ports, so their
// values are fixed; line and node state codes are internal only.
package coh_pkg;
    typedef enum logic [1:0] {
        LN_INV = 2'd0,
        LN_SHR = 2'd1,
        LN_EXC = 2'd2
    } line_st_e;

    typedef enum logic [1:0] {
        BC_NONE   = 2'd0,
        BC_RDMISS = 2'd1,
        BC_WRMISS = 2'd2,
        BC_WBACK  = 2'd3
    } bus_cmd_e;

    typedef enum logic [1:0] {
        ND_IDLE  = 2'd0,
        ND_EVICT = 2'd1,
        ND_MISS  = 2'd2
    } node_st_e;
endpackage

// File: rtl/coh_line_store.sv
// Direct-mapped line store: state, tag and data per line.
// Two asynchronous read ports (processor side, snoop side) and one write port.
// Assumes: the controller never needs two writes in one cycle.
module coh_line_store
    import coh_pkg::*;
#(
    parameter int LINES  = 4,
    parameter int TAG_W  = 6,
    parameter int DATA_W = 16,
    parameter int IDX_W  = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  ra_idx,
    output line_st_e          ra_state,
    output logic [TAG_W-1:0]  ra_tag,
    output logic [DATA_W-1:0] ra_data,
    input  logic [IDX_W-1:0]  rb_idx,
    output line_st_e          rb_state,
    output logic [TAG_W-1:0]  rb_tag,
    output logic [DATA_W-1:0] rb_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  line_st_e          wr_state,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data
);
    line_st_e          st_q   [LINES];
    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [DATA_W-1:0] data_q [LINES];

    // Read ports: plain array lookups.
    assign ra_state = st_q[ra_idx];
    assign ra_tag   = tag_q[ra_idx];
    assign ra_data  = data_q[ra_idx];
    assign rb_state = st_q[rb_idx];
    assign rb_tag   = tag_q[rb_idx];
    assign rb_data  = data_q[rb_idx];

    // Array update: clear everything on reset, else single-port write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) begin
                st_q[i]   <= LN_INV;
                tag_q[i]  <= '0;
                data_q[i] <= '0;
            end
        end else if (wr_en) begin
            st_q[wr_idx]   <= wr_state;
            tag_q[wr_idx]  <= wr_tag;
            data_q[wr_idx] <= wr_data;
        end
    end
endmodule

// File: rtl/coh_node_ctrl.sv
// One node's coherence controller: processor side and snoop side share one
// three-state line store. Snoops win over processor work in any cycle in
// which a foreign transaction is on the bus.
// Assumes: the processor holds request and operands until cpu_done; a bus
// transaction completes in the cycle it is granted.
module coh_node_ctrl
    import coh_pkg::*;
#(
    parameter int NODE_ID = 0,
    parameter int NODES   = 2,
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 16,
    parameter int LINES   = 4,
    parameter int SRC_W   = (NODES > 1) ? $clog2(NODES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_done,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              b_req,
    output bus_cmd_e          b_cmd,
    output logic [ADDR_W-1:0] b_addr,
    output logic [DATA_W-1:0] b_wdata,
    input  logic              b_gnt,
    input  logic              s_valid,
    input  logic [SRC_W-1:0]  s_src,
    input  bus_cmd_e          s_cmd,
    input  logic [ADDR_W-1:0] s_addr,
    input  logic [DATA_W-1:0] s_rdata,
    output logic              snp_supply,
    output logic [DATA_W-1:0] snp_data
);
    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = ADDR_W - IDX_W;
    localparam logic [SRC_W-1:0] MY_ID = SRC_W'(NODE_ID);

    node_st_e          st_q, st_d;
    logic              p_we, cap;
    logic [ADDR_W-1:0] p_addr, cur_addr;
    logic [DATA_W-1:0] p_wdata;
    logic [IDX_W-1:0]  ca_idx, sb_idx;
    logic [TAG_W-1:0]  cur_tag, ca_tag, sb_tag;
    line_st_e          ca_state, sb_state;
    logic [DATA_W-1:0] ca_data, sb_data;
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    line_st_e          wr_state;
    logic [TAG_W-1:0]  wr_tag;
    logic [DATA_W-1:0] wr_data;
    logic              snoop_act, cpu_hit, victim_dirty, sn_hit;

    coh_line_store #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .ra_idx(ca_idx), .ra_state(ca_state), .ra_tag(ca_tag), .ra_data(ca_data),
        .rb_idx(sb_idx), .rb_state(sb_state), .rb_tag(sb_tag), .rb_data(sb_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_state(wr_state), .wr_tag(wr_tag), .wr_data(wr_data)
    );

    // Lookup addressing: a new request while idle, the latched miss otherwise.
    assign cur_addr     = (st_q == ND_IDLE) ? cpu_addr : p_addr;
    assign ca_idx       = cur_addr[IDX_W-1:0];
    assign cur_tag      = cur_addr[ADDR_W-1:IDX_W];
    assign sb_idx       = s_addr[IDX_W-1:0];
    assign snoop_act    = s_valid && (s_src != MY_ID);
    assign cpu_hit      = (ca_state != LN_INV) && (ca_tag == cur_tag);
    assign victim_dirty = (ca_state == LN_EXC) && (ca_tag != cur_tag);
    assign sn_hit       = snoop_act && (sb_state != LN_INV) && (sb_tag == s_addr[ADDR_W-1:IDX_W]);
    assign snp_supply   = sn_hit && (sb_state == LN_EXC) &&
                          ((s_cmd == BC_RDMISS) || (s_cmd == BC_WRMISS));
    assign snp_data     = sb_data;

    // Bus-side request: write-back of a dirty victim, then the miss itself.
    always_comb begin
        b_req   = 1'b0;
        b_cmd   = BC_NONE;
        b_addr  = p_addr;
        b_wdata = ca_data;
        if (st_q == ND_EVICT) begin
            b_req  = victim_dirty;
            b_cmd  = BC_WBACK;
            b_addr = {ca_tag, ca_idx};
        end else if (st_q == ND_MISS) begin
            b_req = 1'b1;
            b_cmd = p_we ? BC_WRMISS : BC_RDMISS;
        end
    end

    // Line machine: snoop update first, otherwise processor-side progress.
    always_comb begin
        st_d      = st_q;
        cap       = 1'b0;
        wr_en     = 1'b0;
        wr_idx    = ca_idx;
        wr_state  = ca_state;
        wr_tag    = ca_tag;
        wr_data   = ca_data;
        cpu_done  = 1'b0;
        cpu_rdata = ca_data;
        if (snoop_act) begin
            if (sn_hit && (s_cmd == BC_WRMISS || (s_cmd == BC_RDMISS && sb_state == LN_EXC))) begin
                wr_en    = 1'b1;
                wr_idx   = sb_idx;
                wr_state = (s_cmd == BC_WRMISS) ? LN_INV : LN_SHR;
                wr_tag   = sb_tag;
                wr_data  = sb_data;
            end
        end else begin
            unique case (st_q)
                ND_IDLE: begin
                    if (cpu_req) begin
                        if (cpu_hit && !cpu_we) begin
                            cpu_done = 1'b1;
                        end else if (cpu_hit && cpu_we && ca_state == LN_EXC) begin
                            cpu_done = 1'b1;
                            wr_en    = 1'b1;
                            wr_data  = cpu_wdata;
                        end else begin
                            cap  = 1'b1;
                            st_d = victim_dirty ? ND_EVICT : ND_MISS;
                        end
                    end
                end
                ND_EVICT: begin
                    if (!victim_dirty) begin
                        st_d = ND_MISS;
                    end else if (b_gnt) begin
                        wr_en    = 1'b1;
                        wr_state = LN_INV;
                        st_d     = ND_MISS;
                    end
                end
                ND_MISS: begin
                    if (b_gnt) begin
                        wr_en     = 1'b1;
                        wr_state  = p_we ? LN_EXC : LN_SHR;
                        wr_tag    = cur_tag;
                        wr_data   = p_we ? p_wdata : s_rdata;
                        cpu_done  = 1'b1;
                        cpu_rdata = s_rdata;
                        st_d      = ND_IDLE;
                    end
                end
                default: st_d = ND_IDLE;
            endcase
        end
    end

    // State register and latch of the pending miss operands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ND_IDLE;
            p_we    <= 1'b0;
            p_addr  <= '0;
            p_wdata <= '0;
        end else begin
            st_q <= st_d;
            if (cap) begin
                p_we    <= cpu_we;
                p_addr  <= cpu_addr;
                p_wdata <= cpu_wdata;
            end
        end
    end

    // R8: no processor completion while a foreign transaction is snooped.
    a_r8_snoop_stall: assert property (@(posedge clk) disable iff (!rst_n)
        snoop_act |-> !cpu_done);

    // R4: a granted write miss is the completing cycle of the write.
    a_r4_write_on_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (b_gnt && b_cmd == BC_WRMISS) |-> (cpu_done && cpu_we));

    // R7: a write-back is always followed by the pending miss request.
    a_r7_wb_then_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (b_gnt && b_cmd == BC_WBACK) |=> (b_req && (b_cmd == BC_RDMISS || b_cmd == BC_WRMISS)));
endmodule

// File: rtl/coh_bus_arbiter.sv
// Round-robin bus arbiter: one grant per cycle among requesters.
// Assumes: requests are held until granted; the node after the last
// granted node has top priority, node 0 first after reset.
module coh_bus_arbiter #(
    parameter int NODES = 2,
    parameter int SRC_W = (NODES > 1) ? $clog2(NODES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NODES-1:0] req,
    output logic [NODES-1:0] gnt,
    output logic [SRC_W-1:0] src
);
    logic [SRC_W-1:0] last_q;

    // Grant selection: scan from the node after the last winner.
    always_comb begin
        logic found;
        found = 1'b0;
        gnt   = '0;
        src   = '0;
        for (int k = 1; k <= NODES; k++) begin
            int cand;
            cand = (int'(last_q) + k) % NODES;
            if (!found && req[cand]) begin
                gnt[cand] = 1'b1;
                src       = SRC_W'(cand);
                found     = 1'b1;
            end
        end
    end

    // Remember the winner for rotation.
    always_ff @(posedge clk) begin
        if (!rst_n)      last_q <= SRC_W'(NODES - 1);
        else if (|gnt)   last_q <= src;
    end

    // R9: single grant, only to a requester.
    a_r9_gnt_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));
    a_r9_gnt_to_req: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt & ~req) == '0);
endmodule

// File: rtl/coh_mem_stub.sv
// Memory stub on the bus: answers misses, absorbs write-backs, and records
// the value a dirty owner supplies when it aborts the memory response.
// Assumes: the address space is small enough to hold in registers.
module coh_mem_stub
    import coh_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid,
    input  bus_cmd_e          cmd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              abort,
    input  logic [DATA_W-1:0] sdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int WORDS = 1 << ADDR_W;
    logic [DATA_W-1:0] mem_q [WORDS];

    // Read port for miss responses.
    assign rdata = mem_q[addr];

    // Memory update: clear on reset, write-back data or intervention data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) mem_q[i] <= '0;
        end else if (valid && cmd == BC_WBACK) begin
            mem_q[addr] <= wdata;
        end else if (valid && abort) begin
            mem_q[addr] <= sdata;
        end
    end

    // R5: an abort only ever accompanies a miss transaction.
    a_r5_abort_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
        abort |-> (valid && (cmd == BC_RDMISS || cmd == BC_WRMISS)));
endmodule

// File: rtl/coh_snoop_cluster.sv
// Top: NODES coherence controllers, a round-robin arbiter, the shared
// broadcast bus and a memory stub. The granted node drives the bus; all
// others snoop it in the same cycle; a dirty owner overrides memory data.
// Assumes: processor ports are flat vectors, node i at slice i.
module coh_snoop_cluster
    import coh_pkg::*;
#(
    parameter int NODES  = 2,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int LINES  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NODES-1:0]         cpu_req,
    input  logic [NODES-1:0]         cpu_we,
    input  logic [NODES*ADDR_W-1:0]  cpu_addr,
    input  logic [NODES*DATA_W-1:0]  cpu_wdata,
    output logic [NODES-1:0]         cpu_done,
    output logic [NODES*DATA_W-1:0]  cpu_rdata,
    output logic                     bus_valid,
    output logic [1:0]               bus_cmd,
    output logic [ADDR_W-1:0]        bus_addr,
    output logic                     bus_abort
);
    localparam int SRC_W = (NODES > 1) ? $clog2(NODES) : 1;

    logic [NODES-1:0]  n_req, gnt, sup;
    bus_cmd_e          n_cmd   [NODES];
    logic [ADDR_W-1:0] n_addr  [NODES];
    logic [DATA_W-1:0] n_wdata [NODES];
    logic [DATA_W-1:0] n_sdata [NODES];
    logic [SRC_W-1:0]  src;
    bus_cmd_e          b_cmd;
    logic [ADDR_W-1:0] b_addr;
    logic [DATA_W-1:0] b_wdata, sup_data, mem_rdata, b_rdata;

    coh_bus_arbiter #(.NODES(NODES), .SRC_W(SRC_W)) u_arb (
        .clk(clk), .rst_n(rst_n), .req(n_req), .gnt(gnt), .src(src)
    );

    generate
        for (genvar g = 0; g < NODES; g++) begin : g_node
            coh_node_ctrl #(
                .NODE_ID(g), .NODES(NODES), .ADDR_W(ADDR_W),
                .DATA_W(DATA_W), .LINES(LINES), .SRC_W(SRC_W)
            ) u_node (
                .clk(clk), .rst_n(rst_n),
                .cpu_req(cpu_req[g]), .cpu_we(cpu_we[g]),
                .cpu_addr(cpu_addr[g*ADDR_W +: ADDR_W]),
                .cpu_wdata(cpu_wdata[g*DATA_W +: DATA_W]),
                .cpu_done(cpu_done[g]),
                .cpu_rdata(cpu_rdata[g*DATA_W +: DATA_W]),
                .b_req(n_req[g]), .b_cmd(n_cmd[g]), .b_addr(n_addr[g]),
                .b_wdata(n_wdata[g]), .b_gnt(gnt[g]),
                .s_valid(bus_valid), .s_src(src), .s_cmd(b_cmd),
                .s_addr(b_addr), .s_rdata(b_rdata),
                .snp_supply(sup[g]), .snp_data(n_sdata[g])
            );
        end
    endgenerate

    // Bus multiplexer: the granted node drives; supplied data is OR-merged.
    always_comb begin
        b_cmd    = BC_NONE;
        b_addr   = '0;
        b_wdata  = '0;
        sup_data = '0;
        for (int i = 0; i < NODES; i++) begin
            if (gnt[i]) begin
                b_cmd   = n_cmd[i];
                b_addr  = n_addr[i];
                b_wdata = n_wdata[i];
            end
            if (sup[i]) sup_data = sup_data | n_sdata[i];
        end
    end

    assign bus_valid = |gnt;
    assign bus_abort = |sup;
    assign b_rdata   = bus_abort ? sup_data : mem_rdata;
    assign bus_cmd   = b_cmd;
    assign bus_addr  = b_addr;

    coh_mem_stub #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk(clk), .rst_n(rst_n), .valid(bus_valid), .cmd(b_cmd),
        .addr(b_addr), .wdata(b_wdata), .abort(bus_abort),
        .sdata(sup_data), .rdata(mem_rdata)
    );

    // R10: never more than one supplying owner.
    a_r10_single_supplier: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sup));
endmodule

// File: tb/coh_snoop_cluster_tb.sv
// Scoreboard bench: driver tasks queue expected bus transactions and read
// values; a monitor at the falling edge pops and compares them.
module coh_snoop_cluster_tb;
    localparam int NODES = 2;
    localparam int AW = 8;
    localparam int DW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NODES-1:0]    cpu_req = '0;
    logic [NODES-1:0]    cpu_we = '0;
    logic [NODES*AW-1:0] cpu_addr = '0;
    logic [NODES*DW-1:0] cpu_wdata = '0;
    logic [NODES-1:0]    cpu_done;
    logic [NODES*DW-1:0] cpu_rdata;
    logic                bus_valid;
    logic [1:0]          bus_cmd;
    logic [AW-1:0]       bus_addr;
    logic                bus_abort;

    int tests = 0;
    int fails = 0;

    logic [1:0]  exp_cmd[$];
    logic [7:0]  exp_addr[$];
    logic        exp_abt[$];
    string       exp_btag[$];
    logic [15:0] exp_rd0[$];
    logic [15:0] exp_rd1[$];
    string       rtag0[$];
    string       rtag1[$];

    always #5 clk = ~clk;

    coh_snoop_cluster #(.NODES(NODES), .ADDR_W(AW), .DATA_W(DW), .LINES(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_done(cpu_done),
        .cpu_rdata(cpu_rdata), .bus_valid(bus_valid), .bus_cmd(bus_cmd),
        .bus_addr(bus_addr), .bus_abort(bus_abort)
    );

    function automatic void chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
        end
    endfunction

    function automatic void push_bus(logic [1:0] c, logic [7:0] a, logic ab, string tag);
        exp_cmd.push_back(c);
        exp_addr.push_back(a);
        exp_abt.push_back(ab);
        exp_btag.push_back(tag);
    endfunction

    // Monitor: compare every bus transaction and every read completion.
    always @(negedge clk) begin
        if (rst_n) begin
            if (bus_valid) begin
                if (exp_cmd.size() == 0) begin
                    chk("R2", "unexpected bus transaction cmd", {30'd0, bus_cmd}, 32'hFFFF_FFFF);
                end else begin
                    string t;
                    t = exp_btag.pop_front();
                    chk(t, "bus cmd", {30'd0, bus_cmd}, {30'd0, exp_cmd.pop_front()});
                    chk(t, "bus addr", {24'd0, bus_addr}, {24'd0, exp_addr.pop_front()});
                    chk(t, "bus abort", {31'd0, bus_abort}, {31'd0, exp_abt.pop_front()});
                end
            end
            if (cpu_done[0] && !cpu_we[0]) begin
                if (exp_rd0.size() == 0) chk("R10", "node0 unexpected read", 32'd1, 32'd0);
                else chk(rtag0.pop_front(), "node0 rdata", {16'd0, cpu_rdata[15:0]}, {16'd0, exp_rd0.pop_front()});
            end
            if (cpu_done[1] && !cpu_we[1]) begin
                if (exp_rd1.size() == 0) chk("R10", "node1 unexpected read", 32'd1, 32'd0);
                else chk(rtag1.pop_front(), "node1 rdata", {16'd0, cpu_rdata[31:16]}, {16'd0, exp_rd1.pop_front()});
            end
        end
    end

    // Driver: one processor access, checks the completion latency in cycles.
    task automatic op(input int n, input bit we, input logic [7:0] a, input logic [15:0] d,
                      input logic [15:0] exp_rd, input int exp_wait, input string tag);
        int waited;
        @(posedge clk);
        #2;
        cpu_req[n] = 1'b1;
        cpu_we[n] = we;
        cpu_addr[n*AW +: AW] = a;
        cpu_wdata[n*DW +: DW] = d;
        if (!we) begin
            if (n == 0) begin exp_rd0.push_back(exp_rd); rtag0.push_back(tag); end
            else begin exp_rd1.push_back(exp_rd); rtag1.push_back(tag); end
        end
        waited = 0;
        do begin
            @(negedge clk);
            waited++;
        end while (!cpu_done[n]);
        @(posedge clk);
        #2;
        cpu_req[n] = 1'b0;
        chk(tag, "completion cycles", waited, exp_wait);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(20000 * 10);
        tests++;
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state at the ports
        chk("R1", "done during reset", {30'd0, cpu_done}, 32'd0);
        chk("R1", "bus idle during reset", {31'd0, bus_valid}, 32'd0);
        rst_n = 1'b1;

        // R1 R3: first read misses, memory is zero, line filled Shared
        push_bus(2'd1, 8'h10, 1'b0, "R3");
        op(0, 0, 8'h10, 16'h0, 16'h0000, 2, "R1");
        // R2: read hit on Shared, no bus
        op(0, 0, 8'h10, 16'h0, 16'h0000, 1, "R2");
        push_bus(2'd1, 8'h10, 1'b0, "R3");
        op(1, 0, 8'h10, 16'h0, 16'h0000, 2, "R3");
        // R4: write to Shared is a write miss; other copy invalidated (R6)
        push_bus(2'd2, 8'h10, 1'b0, "R4");
        op(0, 1, 8'h10, 16'h1111, 16'h0, 2, "R4");
        // R2: write hit on Exclusive, no bus
        op(0, 1, 8'h10, 16'h2222, 16'h0, 1, "R2");
        // R5 R6: invalidated node misses, owner intervenes with abort
        push_bus(2'd1, 8'h10, 1'b1, "R5");
        op(1, 0, 8'h10, 16'h0, 16'h2222, 2, "R5");
        // R5: owner now Shared, read hits locally
        op(0, 0, 8'h10, 16'h0, 16'h2222, 1, "R5");
        // R5 R6: write from Shared needs the bus; Shared peer dropped, no abort
        push_bus(2'd2, 8'h10, 1'b0, "R6");
        op(0, 1, 8'h10, 16'h3333, 16'h0, 2, "R5");
        push_bus(2'd1, 8'h10, 1'b1, "R6");
        op(1, 0, 8'h10, 16'h0, 16'h3333, 2, "R6");
        // R6: foreign write miss to an Exclusive line: supply, abort, invalidate
        push_bus(2'd2, 8'h05, 1'b0, "R4");
        op(1, 1, 8'h05, 16'h4444, 16'h0, 2, "R4");
        push_bus(2'd2, 8'h05, 1'b1, "R6");
        op(0, 1, 8'h05, 16'h5555, 16'h0, 2, "R6");
        push_bus(2'd1, 8'h05, 1'b1, "R6");
        op(1, 0, 8'h05, 16'h0, 16'h5555, 2, "R6");
        // R7: conflict on a clean victim needs no write-back
        push_bus(2'd2, 8'h20, 1'b0, "R7");
        op(0, 1, 8'h20, 16'h7777, 16'h0, 2, "R7");
        // R7: conflict on a dirty victim: write-back first, then the miss
        push_bus(2'd3, 8'h20, 1'b0, "R7");
        push_bus(2'd2, 8'h10, 1'b0, "R7");
        op(0, 1, 8'h10, 16'h6666, 16'h0, 3, "R7");
        // R7: written-back value now comes from memory
        push_bus(2'd1, 8'h20, 1'b0, "R7");
        op(1, 0, 8'h20, 16'h0, 16'h7777, 2, "R7");
        // R10: last write wins via intervention
        push_bus(2'd1, 8'h10, 1'b1, "R10");
        op(1, 0, 8'h10, 16'h0, 16'h6666, 2, "R10");

        // R8: a hit arriving during a foreign transaction is held one cycle
        push_bus(2'd1, 8'h09, 1'b0, "R8");
        fork
            op(1, 0, 8'h09, 16'h0, 16'h0000, 2, "R8");
            begin
                @(posedge clk);
                op(0, 0, 8'h05, 16'h0, 16'h5555, 2, "R8");
            end
        join

        // R9: simultaneous misses, node 0 first after node 1's grant
        push_bus(2'd1, 8'h31, 1'b0, "R9");
        push_bus(2'd1, 8'h42, 1'b0, "R9");
        fork
            op(0, 0, 8'h31, 16'h0, 16'h0000, 2, "R9");
            op(1, 0, 8'h42, 16'h0, 16'h0000, 3, "R9");
        join

        repeat (4) @(negedge clk);
        chk("R10", "pending bus items", exp_cmd.size(), 32'd0);
        chk("R10", "pending reads", exp_rd0.size() + exp_rd1.size(), 32'd0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule